// File: doc/BRIEF.md
# UART Register File and Interrupt Prioritiser

This block is the host-facing register file of a simple UART with no FIFO. A host reaches it through a 32-bit memory-mapped port with word-aligned byte offsets. It holds a single received byte, the line and modem status, and the write-only control values (interrupt enables, line control, modem control and baud divisor). It drives those control values out to the serial engine, which sits outside this block. It raises one interrupt line and reports the highest-priority pending cause in an identification register.

The receive engine hands bytes in with a valid strobe. A ready output tells it that the holding register is empty. A serial line cannot stall, so a byte that arrives while the holder is full is still taken: it replaces the held byte and flags an overrun. Bytes written by the host go out to the transmit engine through a valid/ready handshake. The engine's idle indication sets the transmitter-empty flag once the last byte has left. Modem pin levels and change pulses come from an external sampler.

Read data is registered and appears one cycle after the read request. The interrupt identification and the interrupt line are derived from the stored state, so they reflect every access from the cycle after it.

Top module: `uart_regif`

## Requirements
- R1: After reset, line status reads 0x60 (bit5 holding-empty and bit6 transmitter-empty set), identification reads 0x01, the interrupt is low, receive ready is high, transmit valid is low, and all control outputs are zero.
- R2: An access is taken only when bus_be is 4'hF, the byte offset is a multiple of 4 and it is below 0x20. Word index 0 is data, 1 enables, 2 identification, 3 line control, 4 modem control, 5 line status, 6 modem status and 7 divisor. Every read request loads bus_rdata on the next cycle, with zero for a rejected access or a write-only register (indices 1, 3, 4, 7). A rejected access has no other effect.
- R3: A write to index 1 stores bits 3:0 as the interrupt enables (bit0 receive data, bit1 holding-empty, bit2 line error, bit3 modem). A write to index 3 drives bits 6:0 onto line_ctrl, index 4 drives bits 1:0 onto modem_ctrl, and index 7 drives the low DIV_W bits onto baud_div, each from the next cycle.
- R4: A cycle with rx_valid high stores rx_byte and sets data-ready (line status bit0), and rx_ready is low while data-ready is set.
- R5: A read of index 0 returns the held byte and clears data-ready.
- R6: A byte arriving while data-ready is set, without a data read in the same cycle, sets overrun (bit1), and the new byte replaces the held one.
- R7: rx_perr, rx_ferr and rx_brk, sampled with rx_valid, set line status bits 2, 3 and 4. A read of index 5 clears bits 1 to 4, and a flag raised in that same cycle survives.
- R8: Modem status bits 7:4 hold modem_lvl from the previous cycle. Each modem_chg bit sets the matching bit of 3:0, and a read of index 6 clears bits 3:0, with new pulses winning.
- R9: A data write drives its low byte on tx_byte with tx_valid high from the next cycle and clears status bits 5 and 6. The byte is held until tx_ready, and a further write before acceptance replaces it.
- R10: Acceptance (tx_valid and tx_ready) drops tx_valid and sets bit5. Bit6 sets in a later cycle in which tx_idle is high and no byte is pending.
- R11: Identification bits 2:0 read 3'b110 for a line error with bit2 enabled, otherwise 3'b100 for data-ready with bit0 enabled, otherwise 3'b010 for holding-empty with bit1 enabled, otherwise 3'b000 for a modem change with bit3 enabled, otherwise 3'b001. irq is high exactly when the code is not 3'b001.
- R12: Writes to indices 2, 5 and 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_be | input | 4 | Byte enables, all four required |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error with this byte |
| rx_ferr | input | 1 | Framing error with this byte |
| rx_brk | input | 1 | Break seen with this byte |
| rx_ready | output | 1 | Holding register empty |
| tx_valid | output | 1 | Byte pending for the transmitter |
| tx_byte | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_idle | input | 1 | Transmitter has nothing in flight |
| modem_lvl | input | 4 | Sampled CTS, DSR, RI, DCD (bit0 to bit3) |
| modem_chg | input | 4 | Change pulses for the same four pins |
| line_ctrl | output | 7 | Line control value |
| modem_ctrl | output | 2 | Modem control value |
| baud_div | output | DIV_W | Baud divisor |

## Verification
The assertions check the cycle-level handshake rules on every cycle. A pending transmit byte stays stable until it is accepted and drops on acceptance. Receive ready falls after every arrival. A rejected access leaves the control outputs unchanged, a line-control write lands on the next cycle, and the interrupt stays low with no enables. Only the bench's scenarios can show the read-side effects and the value contents. These include overrun versus replacement, the clear-on-read of the error and delta flags and their set-wins ordering, the full interrupt priority ladder, and the order in which the two transmit-empty bits recover.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  typedef enum logic [2:0] {
    RS_DATA  = 3'd0,
    RS_IEN   = 3'd1,
    RS_IDENT = 3'd2,
    RS_LCTL  = 3'd3,
    RS_MCTL  = 3'd4,
    RS_LSTAT = 3'd5,
    RS_MSTAT = 3'd6,
    RS_DIVR  = 3'd7
  } reg_sel_e;

  localparam int NUM_CAUSES = 4;

  localparam logic [2:0] ID_LINE = 3'b110;
  localparam logic [2:0] ID_RXD  = 3'b100;
  localparam logic [2:0] ID_THE  = 3'b010;
  localparam logic [2:0] ID_MDM  = 3'b000;
  localparam logic [2:0] ID_NONE = 3'b001;

  // cause index 0 is the highest priority
  function automatic logic [2:0] cause_code(input int idx);
    case (idx)
      0:       return ID_LINE;
      1:       return ID_RXD;
      2:       return ID_THE;
      default: return ID_MDM;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [2:0]        rx_err,     // {brk, ferr, perr}
  input  logic              data_rd,
  input  logic              stat_rd,
  output logic              rx_ready,
  output logic [DATA_W-1:0] hold_byte,
  output logic              dr,
  output logic [3:0]        err_flags   // {brk, ferr, perr, ovr}
);

  logic [DATA_W-1:0] byte_q;
  logic              dr_q, dr_d;
  logic [3:0]        err_q, err_d;
  logic              byte_en;

  assign byte_en = rx_valid;

  always_comb begin
    dr_d  = dr_q;
    err_d = stat_rd ? 4'b0000 : err_q;
    if (data_rd) dr_d = 1'b0;
    if (rx_valid) begin
      dr_d  = 1'b1;
      err_d = err_d | {rx_err, (dr_q && !data_rd)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q  <= 1'b0;
      err_q <= 4'b0000;
    end else begin
      dr_q  <= dr_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
    end else if (byte_en) begin
      byte_q <= rx_byte;
    end
  end

  assign rx_ready  = !dr_q;
  assign hold_byte = byte_q;
  assign dr        = dr_q;
  assign err_flags = err_q;

endmodule

// File: rtl/uart_tx_hand.sv
module uart_tx_hand #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wbyte,
  input  logic              tx_ready,
  input  logic              tx_idle,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_byte,
  output logic              thre,
  output logic              temt
);

  logic              pend_q, pend_d;
  logic              thre_q, thre_d;
  logic              temt_q, temt_d;
  logic [DATA_W-1:0] byte_q;
  logic              byte_en;

  assign byte_en = data_wr;

  always_comb begin
    pend_d = pend_q;
    thre_d = thre_q;
    temt_d = temt_q;
    if (data_wr) begin
      pend_d = 1'b1;
      thre_d = 1'b0;
      temt_d = 1'b0;
    end else if (pend_q && tx_ready) begin
      pend_d = 1'b0;
      thre_d = 1'b1;
    end else if (!pend_q && tx_idle) begin
      temt_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      thre_q <= 1'b1;
      temt_q <= 1'b1;
    end else begin
      pend_q <= pend_d;
      thre_q <= thre_d;
      temt_q <= temt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
    end else if (byte_en) begin
      byte_q <= wbyte;
    end
  end

  assign tx_valid = pend_q;
  assign tx_byte  = byte_q;
  assign thre     = thre_q;
  assign temt     = temt_q;

endmodule

// File: rtl/uart_mdm_stat.sv
module uart_mdm_stat #(
  parameter int PINS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] modem_lvl,
  input  logic [PINS-1:0] modem_chg,
  input  logic            stat_rd,
  output logic [PINS-1:0] lvl,
  output logic [PINS-1:0] delta
);

  logic [PINS-1:0] lvl_q;
  logic [PINS-1:0] dlt_q, dlt_d;

  always_comb begin
    dlt_d = (stat_rd ? '0 : dlt_q) | modem_chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      dlt_q <= '0;
    end else begin
      lvl_q <= modem_lvl;
      dlt_q <= dlt_d;
    end
  end

  assign lvl   = lvl_q;
  assign delta = dlt_q;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_regif_pkg::*;
(
  input  logic [3:0] ien,        // {mdm, line, the, rxd}
  input  logic       line_err,
  input  logic       dr,
  input  logic       thre,
  input  logic       mdm_any,
  output logic [2:0] ident,
  output logic       irq
);

  logic [NUM_CAUSES-1:0] hit;

  // index order follows priority, 0 highest
  assign hit[0] = line_err && ien[2];
  assign hit[1] = dr       && ien[0];
  assign hit[2] = thre     && ien[1];
  assign hit[3] = mdm_any  && ien[3];

  always_comb begin
    ident = ID_NONE;
    for (int i = NUM_CAUSES - 1; i >= 0; i--) begin
      if (hit[i]) ident = cause_code(i);
    end
  end

  assign irq = |hit;

endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_brk,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_ready,
  input  logic              tx_idle,
  input  logic [3:0]        modem_lvl,
  input  logic [3:0]        modem_chg,
  output logic [6:0]        line_ctrl,
  output logic [1:0]        modem_ctrl,
  output logic [DIV_W-1:0]  baud_div
);

  localparam int BYTE_W = 8;
  localparam int IEN_W  = 4;
  localparam int LCTL_W = 7;
  localparam int MCTL_W = 2;
  localparam int SEL_LO = 2;
  localparam int SEL_HI = 4;

  // access decode
  logic     acc_ok;
  logic     hi_zero;
  reg_sel_e sel;
  logic     rd_acc, wr_acc;

  assign hi_zero = (bus_addr[ADDR_W-1:SEL_HI+1] == '0);
  assign acc_ok  = bus_sel && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00) && hi_zero;
  assign sel     = reg_sel_e'(bus_addr[SEL_HI:SEL_LO]);
  assign rd_acc  = acc_ok && !bus_wr;
  assign wr_acc  = acc_ok && bus_wr;

  logic data_rd, lstat_rd, mstat_rd, data_wr;
  assign data_rd  = rd_acc && (sel == RS_DATA);
  assign lstat_rd = rd_acc && (sel == RS_LSTAT);
  assign mstat_rd = rd_acc && (sel == RS_MSTAT);
  assign data_wr  = wr_acc && (sel == RS_DATA);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  // write-only control registers
  logic [IEN_W-1:0]  ier_q;
  logic [LCTL_W-1:0] lcr_q;
  logic [MCTL_W-1:0] mcr_q;
  logic [DIV_W-1:0]  div_q;
  logic ier_en, lcr_en, mcr_en, div_en;

  assign ier_en = wr_acc && (sel == RS_IEN);
  assign lcr_en = wr_acc && (sel == RS_LCTL);
  assign mcr_en = wr_acc && (sel == RS_MCTL);
  assign div_en = wr_acc && (sel == RS_DIVR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= '0;
      lcr_q <= '0;
      mcr_q <= '0;
      div_q <= '0;
    end else begin
      if (ier_en) ier_q <= bus_wdata[IEN_W-1:0];
      if (lcr_en) lcr_q <= bus_wdata[LCTL_W-1:0];
      if (mcr_en) mcr_q <= bus_wdata[MCTL_W-1:0];
      if (div_en) div_q <= bus_wdata[DIV_W-1:0];
    end
  end

  assign line_ctrl  = lcr_q;
  assign modem_ctrl = mcr_q;
  assign baud_div   = div_q;

  // receive holding
  logic [BYTE_W-1:0] hold_byte;
  logic              dr;
  logic [3:0]        err_flags;

  uart_rx_hold #(.DATA_W(BYTE_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rx_err    ({rx_brk, rx_ferr, rx_perr}),
    .data_rd   (data_rd),
    .stat_rd   (lstat_rd),
    .rx_ready  (rx_ready),
    .hold_byte (hold_byte),
    .dr        (dr),
    .err_flags (err_flags)
  );

  // transmit handshake
  logic thre, temt;

  uart_tx_hand #(.DATA_W(BYTE_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_wr  (data_wr),
    .wbyte    (bus_wdata[BYTE_W-1:0]),
    .tx_ready (tx_ready),
    .tx_idle  (tx_idle),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .thre     (thre),
    .temt     (temt)
  );

  // modem status
  logic [3:0] mlvl, mdelta;

  uart_mdm_stat #(.PINS(4)) u_mdm (
    .clk       (clk),
    .rst_n     (rst_n),
    .modem_lvl (modem_lvl),
    .modem_chg (modem_chg),
    .stat_rd   (mstat_rd),
    .lvl       (mlvl),
    .delta     (mdelta)
  );

  // interrupt identification
  logic [2:0] ident;

  uart_irq_prio u_prio (
    .ien      (ier_q),
    .line_err (|err_flags),
    .dr       (dr),
    .thre     (thre),
    .mdm_any  (|mdelta),
    .ident    (ident),
    .irq      (irq)
  );

  // read path
  logic [6:0]  lsr_val;
  logic [31:0] rd_mux;
  logic [31:0] rdata_q, rdata_d;

  assign lsr_val = {temt, thre, err_flags, dr};

  always_comb begin
    case (sel)
      RS_DATA:  rd_mux = {24'd0, hold_byte};
      RS_IDENT: rd_mux = {29'd0, ident};
      RS_LSTAT: rd_mux = {25'd0, lsr_val};
      RS_MSTAT: rd_mux = {24'd0, mlvl, mdelta};
      default:  rd_mux = 32'd0;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (bus_sel && !bus_wr) rdata_d = acc_ok ? rd_mux : 32'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= 32'd0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_wdata,
  input logic              irq,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [7:0]        tx_byte,
  input logic              tx_ready,
  input logic [6:0]        line_ctrl,
  input logic [1:0]        modem_ctrl,
  input logic [DIV_W-1:0]  baud_div,
  input logic [3:0]        ier,
  input logic              acc_ok
);

  logic dwr, lwr;
  logic unused_chk;
  assign dwr = acc_ok && bus_wr && (bus_addr[4:2] == 3'd0);
  assign lwr = acc_ok && bus_wr && (bus_addr[4:2] == 3'd3);
  assign unused_chk = ^{bus_wdata[31:7], bus_addr[1:0]};

  AST_BAD_ACCESS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_be != 4'hF) |=> ($stable(line_ctrl) && $stable(modem_ctrl) && $stable(baud_div))); // R2

  AST_LCTL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    lwr |=> (line_ctrl == $past(bus_wdata[6:0]))); // R3

  AST_RX_FULL_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_ready); // R4

  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !dwr) |=> (tx_valid && $stable(tx_byte))); // R9

  AST_TX_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !dwr) |=> !tx_valid); // R10

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 4'd0) |-> !irq); // R11

endmodule

bind uart_regif uart_regif_chk #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_be     (bus_be),
  .bus_wdata  (bus_wdata),
  .irq        (irq),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .tx_valid   (tx_valid),
  .tx_byte    (tx_byte),
  .tx_ready   (tx_ready),
  .line_ctrl  (line_ctrl),
  .modem_ctrl (modem_ctrl),
  .baud_div   (baud_div),
  .ier        (ier_q),
  .acc_ok     (acc_ok)
);

// File: tb/uart_regif_test.sv
module uart_regif_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DIV_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [3:0]        bus_be = 4'hF;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              irq;
  logic              rx_valid = 1'b0;
  logic [7:0]        rx_byte = '0;
  logic              rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic              rx_ready;
  logic              tx_valid;
  logic [7:0]        tx_byte;
  logic              tx_ready = 1'b0, tx_idle = 1'b1;
  logic [3:0]        modem_lvl = '0, modem_chg = '0;
  logic [6:0]        line_ctrl;
  logic [1:0]        modem_ctrl;
  logic [DIV_W-1:0]  baud_div;

  int checks = 0;
  int fails  = 0;
  bit chk_en = 1'b0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regif #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready), .tx_idle(tx_idle),
    .modem_lvl(modem_lvl), .modem_chg(modem_chg), .line_ctrl(line_ctrl),
    .modem_ctrl(modem_ctrl), .baud_div(baud_div)
  );

  // behavioural reference model
  bit        m_dr, m_oe, m_pe, m_fe, m_bi, m_thre, m_temt, m_pend;
  bit [7:0]  m_data, m_txb;
  bit [3:0]  m_ier, m_lvl, m_dlt;
  bit [6:0]  m_lcr;
  bit [1:0]  m_mcr;
  bit [15:0] m_div;
  bit [31:0] m_rd;

  function automatic bit [2:0] m_ident();
    if ((m_oe || m_pe || m_fe || m_bi) && m_ier[2]) return 3'b110;
    if (m_dr && m_ier[0])                           return 3'b100;
    if (m_thre && m_ier[1])                         return 3'b010;
    if ((m_dlt != 0) && m_ier[3])                   return 3'b000;
    return 3'b001;
  endfunction

  function automatic bit [7:0] m_lsr();
    return {1'b0, m_temt, m_thre, m_bi, m_fe, m_pe, m_oe, m_dr};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_dr, m_oe, m_pe, m_fe, m_bi, m_pend} = '0;
      m_thre = 1; m_temt = 1;
      m_data = 0; m_txb = 0; m_ier = 0; m_lvl = 0; m_dlt = 0;
      m_lcr = 0; m_mcr = 0; m_div = 0; m_rd = 0;
    end else begin
      bit ok, rd, wr;
      int idx;
      bit old_dr;
      ok  = bus_sel && bus_be == 4'hF && bus_addr[1:0] == 0 && bus_addr < 8'h20;
      idx = int'(bus_addr >> 2);
      rd  = ok && !bus_wr;
      wr  = ok && bus_wr;
      old_dr = m_dr;
      if (bus_sel && !bus_wr) begin
        if (!ok)            m_rd = 0;
        else if (idx == 0)  m_rd = {24'd0, m_data};
        else if (idx == 2)  m_rd = {29'd0, m_ident()};
        else if (idx == 5)  m_rd = {24'd0, m_lsr()};
        else if (idx == 6)  m_rd = {24'd0, m_lvl, m_dlt};
        else                m_rd = 0;
      end
      // receive side
      if (rd && idx == 5) begin m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0; end
      if (rd && idx == 0) m_dr = 0;
      if (rx_valid) begin
        if (old_dr && !(rd && idx == 0)) m_oe = 1;
        m_data = rx_byte; m_dr = 1;
        if (rx_perr) m_pe = 1;
        if (rx_ferr) m_fe = 1;
        if (rx_brk)  m_bi = 1;
      end
      // transmit side
      if (wr && idx == 0) begin
        m_pend = 1; m_txb = bus_wdata[7:0]; m_thre = 0; m_temt = 0;
      end else if (m_pend && tx_ready) begin
        m_pend = 0; m_thre = 1;
      end else if (!m_pend && tx_idle) begin
        m_temt = 1;
      end
      // control
      if (wr && idx == 1) m_ier = bus_wdata[3:0];
      if (wr && idx == 3) m_lcr = bus_wdata[6:0];
      if (wr && idx == 4) m_mcr = bus_wdata[1:0];
      if (wr && idx == 7) m_div = bus_wdata[15:0];
      // modem
      if (rd && idx == 6) m_dlt = 0;
      m_dlt = m_dlt | modem_chg;
      m_lvl = modem_lvl;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_en && !done) begin
      chk("R4 rx_ready",   {31'd0, rx_ready}, {31'd0, !m_dr});
      chk("R11 irq",       {31'd0, irq},      {31'd0, m_ident() != 3'b001});
      chk("R9 tx_valid",   {31'd0, tx_valid}, {31'd0, m_pend});
      chk("R9 tx_byte",    {24'd0, tx_byte},  {24'd0, m_txb});
      chk("R3 line_ctrl",  {25'd0, line_ctrl},  {25'd0, m_lcr});
      chk("R3 modem_ctrl", {30'd0, modem_ctrl}, {30'd0, m_mcr});
      chk("R3 baud_div",   {16'd0, baud_div},   {16'd0, m_div});
      chk("R2 rdata",      bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_be = 4'hF;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic push(input logic [7:0] b, input logic [2:0] fl = 3'b000);
    @(negedge clk);
    rx_valid = 1; rx_byte = b; {rx_brk, rx_ferr, rx_perr} = fl;
    @(negedge clk);
    rx_valid = 0; {rx_brk, rx_ferr, rx_perr} = 3'b000;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1;
    chk_en = 1;
    idle(1);

    // R1 reset state
    rd(8'h14, d); chk("R1 lsr reset", d, 32'h60);
    rd(8'h08, d); chk("R1 ident reset", d, 32'h01);
    chk("R1 irq reset", {31'd0, irq}, 0);
    chk("R1 rx_ready reset", {31'd0, rx_ready}, 1);
    chk("R1 line_ctrl reset", {25'd0, line_ctrl}, 0);

    // R3 control writes, R2 write-only reads zero
    wr(8'h0C, 32'hFFFF_FF5B); idle(1);
    chk("R3 lctl", {25'd0, line_ctrl}, 32'h5B);
    wr(8'h10, 32'h3); wr(8'h1C, 32'h1234_0056); idle(1);
    chk("R3 mctl", {30'd0, modem_ctrl}, 32'h3);
    chk("R3 div", {16'd0, baud_div}, 32'h56);
    rd(8'h0C, d); chk("R2 write-only reads zero", d, 0);

    // R2 rejected accesses
    wr(8'h0C, 32'h11, 4'h3); wr(8'h3C, 32'h22); wr(8'h0E, 32'h01); idle(1);
    chk("R2 rejected writes", {25'd0, line_ctrl}, 32'h5B);
    rd(8'h3C, d); chk("R2 beyond range reads zero", d, 0);

    // R12 read-only writes ignored
    wr(8'h14, 32'hFF); wr(8'h08, 32'hFF); wr(8'h18, 32'hFF);
    rd(8'h14, d); chk("R12 lsr unchanged", d, 32'h60);
    rd(8'h08, d); chk("R12 ident unchanged", d, 32'h01);
    rd(8'h18, d); chk("R12 msr unchanged", d, 32'h00);

    // R4 R5 single byte
    push(8'hA5);
    chk("R4 rx_ready low", {31'd0, rx_ready}, 0);
    rd(8'h14, d); chk("R4 data ready", d, 32'h61);
    rd(8'h00, d); chk("R5 data", d, 32'hA5);
    rd(8'h14, d); chk("R5 dr cleared", d, 32'h60);

    // R6 overrun, R7 clear on read
    push(8'h11); push(8'h22);
    rd(8'h14, d); chk("R6 overrun", d, 32'h63);
    rd(8'h14, d); chk("R7 cleared by read", d, 32'h61);
    rd(8'h00, d); chk("R6 newest byte", d, 32'h22);

    // R7 error flags
    push(8'h5A, 3'b101);
    rd(8'h14, d); chk("R7 perr brk", d, 32'h75);
    rd(8'h00, d);
    rd(8'h14, d); chk("R7 after clear", d, 32'h60);

    // R11 priority ladder
    wr(8'h04, 32'h1);
    rd(8'h08, d); chk("R11 none pending", d, 32'h01);
    push(8'h33);
    rd(8'h08, d); chk("R11 rx data", d, 32'h04);
    chk("R11 irq rx", {31'd0, irq}, 1);
    wr(8'h04, 32'h5); push(8'h44);
    rd(8'h08, d); chk("R11 line error", d, 32'h06);
    rd(8'h14, d);
    rd(8'h08, d); chk("R11 back to rx", d, 32'h04);
    rd(8'h00, d);
    rd(8'h08, d); chk("R11 idle", d, 32'h01);
    wr(8'h04, 32'h2);
    rd(8'h08, d); chk("R11 holding empty", d, 32'h02);
    wr(8'h04, 32'h8);
    @(negedge clk); modem_chg = 4'b0100; @(negedge clk); modem_chg = 0;
    rd(8'h08, d); chk("R11 modem", d, 32'h00);
    rd(8'h18, d);
    rd(8'h08, d); chk("R11 modem cleared", d, 32'h01);
    wr(8'h04, 32'h0);

    // R8 modem status
    @(negedge clk); modem_lvl = 4'b1010; modem_chg = 4'b0001;
    @(negedge clk); modem_chg = 0;
    rd(8'h18, d); chk("R8 msr", d, 32'hA1);
    rd(8'h18, d); chk("R8 delta cleared", d, 32'hA0);

    // R9 R10 transmit
    wr(8'h00, 32'h1C3);
    chk("R9 tx_valid", {31'd0, tx_valid}, 1);
    chk("R9 tx_byte", {24'd0, tx_byte}, 32'hC3);
    tx_idle = 0;
    rd(8'h14, d); chk("R9 empties cleared", d, 32'h00);
    wr(8'h00, 32'h7E);
    chk("R9 replaced", {24'd0, tx_byte}, 32'h7E);
    idle(2);
    chk("R9 still held", {31'd0, tx_valid}, 1);
    tx_ready = 1; @(negedge clk); tx_ready = 0;
    chk("R10 accepted", {31'd0, tx_valid}, 0);
    rd(8'h14, d); chk("R10 holding empty", d, 32'h20);
    tx_idle = 1; idle(1);
    rd(8'h14, d); chk("R10 transmitter empty", d, 32'h60);

    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule